// File: doc/BRIEF.md
# Queued Serial Engine Register and Interrupt Controller

This block is the processor-facing register front end of a queued serial engine. The processor reaches a queue memory through two registers: a pointer register and a data-port register. The memory has three regions. Transmit words and command bytes are loaded by the processor and read by the engine. Receive words are written by the engine and read by the processor. Every data-port access advances the pointer, so a queue can be filled or drained with back-to-back accesses to a single register.

The block also holds a run-enable bit and a combined status/interrupt register. The status register has three sticky event flags (queue finished, abort, write collision), an interrupt enable for each flag, two error-response enables and an abort lock-out bit. The queue sequencer is not part of this block. It appears only as input ports: transfer active, the index of the command being executed, a command-completed pulse, end-of-queue, halt and wraparound mode. The block drives a registered interrupt request and a bus error response that rejects a faulting write in place of completing it.

Top module: `spiq_ctrl`

## Requirements
- R1: After reset the control, pointer and status registers all read 0, and `irq` and `run_en` are low.
- R2: Every request cycle is answered by `bus_ack` exactly one cycle later. Read data and `bus_err` are valid with that acknowledge, and `bus_err` is raised only for a rejected write (R7, R9). Register selects: 0 control (bit 0 is the run enable), 1 pointer, 2 data port, 3 status.
- R3: A data-port read, or a data-port write that is accepted, adds one to the 6-bit pointer and wraps from 63 to 0. Pointer regions: 0–15 transmit, 16–31 receive, 32–47 command, 48–63 unmapped. Unmapped reads return 0 and unmapped writes are discarded.
- R4: A data-port write stores the full word into the transmit region, or the low 8 bits into the command region. The processor reads both back through the data port. The engine port returns the transmit and command entries at `eng_rd_idx` one cycle later.
- R5: The processor cannot store into the receive region: such a write is discarded and the pointer still advances. Engine writes to the receive region are read back through the data port.
- R6: A data-port write to command entry `seq_cmd_ptr` while `seq_active` is high sets the collision flag (status bit 2). When the collision error enable (status bit 9) is clear, the write still completes.
- R7: When status bit 9 is set, a colliding write returns `bus_err`, stores nothing and leaves the pointer unchanged. The collision flag is still set.
- R8: A control write with bit 0 = 0, made while `run_en` and `seq_active` are both high, clears `run_en` and sets the abort flag (status bit 1).
- R9: When the abort error enable (status bit 8) is set, that clearing write returns `bus_err`, leaves `run_en` high and does not set the abort flag. This check takes precedence over the lock-out.
- R10: When lock-out (status bit 10) is set and bit 8 is clear, that clearing write is ignored without an error and without an abort. When `seq_active` is low, the processor clears `run_en` normally.
- R11: A `seq_cmd_done` pulse together with `seq_at_end` or `seq_halt` sets the finished flag (status bit 0). The block clears `run_en` on halt, or on end-of-queue outside wraparound. In wraparound mode (`seq_wrap`), end-of-queue sets the flag but keeps `run_en`.
- R12: Status flags are write-1-to-clear, and writing 0 to a flag leaves it unchanged. Interrupt enables (bits 4 finished, 5 abort, 6 collision) and bits 8–10 are written directly and read back. All other bits read 0.
- R13: `irq` is registered. It rises one cycle after an enabled flag is set and falls one cycle after the last enabled flag is cleared. A flag whose enable is clear does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Access answered (one cycle after request) |
| bus_err | output | 1 | Access rejected with an error |
| bus_rdata | output | 16 | Read data, valid with the acknowledge |
| run_en | output | 1 | Run enable for the sequencer |
| irq | output | 1 | Interrupt request |
| seq_active | input | 1 | Transfer in progress |
| seq_cmd_ptr | input | 4 | Index of the command being executed |
| seq_cmd_done | input | 1 | Pulse: the current command completed |
| seq_at_end | input | 1 | Completed command is the end-of-queue entry |
| seq_halt | input | 1 | Halt requested |
| seq_wrap | input | 1 | Wraparound mode |
| eng_rx_we | input | 1 | Engine receive-word write |
| eng_rx_idx | input | 4 | Receive entry index |
| eng_rx_data | input | 16 | Receive word |
| eng_rd_idx | input | 4 | Engine read index for transmit and command |
| eng_tx_data | output | 16 | Transmit word at `eng_rd_idx`, one cycle later |
| eng_cmd_data | output | 8 | Command byte at `eng_rd_idx`, one cycle later |

## Verification
A wrong pointer shows up at the very next data-port read, which returns a neighbouring entry. It also shows up in a pointer readback one access later, because every access moves the pointer. A wrong collision or abort decision appears in the acknowledge cycle of the offending write, as a missing or spurious `bus_err`, and one cycle later as a changed `run_en` or status flag. A wrong flag or enable state shows within two cycles as an `irq` edge that comes early, comes late or never comes. The random phase drives long pointer walks across all four regions, so an off-by-one or a region-decode error appears within a handful of accesses.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int BUS_W = 16;
  localparam int NFLAG = 3;

  // flag indices in the status word (bits 0..2), enables at +IE_LSB
  localparam int F_DONE   = 0;
  localparam int F_ABORT  = 1;
  localparam int F_COLL   = 2;
  localparam int IE_LSB   = 4;
  localparam int CFG_LSB  = 8;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_STAT = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    RG_TX   = 2'd0,
    RG_RX   = 2'd1,
    RG_CMD  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_REG,
    SRC_TX,
    SRC_RX,
    SRC_CMD
  } src_e;

  // packed: bit0 abort error enable, bit1 collision error enable, bit2 lock-out
  typedef struct packed {
    logic lock;
    logic coll_err;
    logic abrt_err;
  } cfg_t;

  function automatic logic [BUS_W-1:0] pack_status(
      input logic [NFLAG-1:0] flags,
      input logic [NFLAG-1:0] ie,
      input cfg_t cfg);
    logic [BUS_W-1:0] w;
    w = '0;
    w[NFLAG-1:0]                 = flags;
    w[IE_LSB+NFLAG-1:IE_LSB]     = ie;
    w[CFG_LSB+2:CFG_LSB]         = cfg;
    return w;
  endfunction
endpackage

// File: rtl/spiq_ram.sv
module spiq_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spiq_ptr.sv
module spiq_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ldata,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= ldata;
    else if (step) ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/spiq_status.sv
module spiq_status
  import spiq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_we,
  input  logic [NFLAG-1:0] w1c,
  input  logic [NFLAG-1:0] ie_in,
  input  cfg_t             cfg_in,
  input  logic             ctl_load,
  input  logic             ctl_val,
  input  logic             abort_evt,
  input  logic             coll_evt,
  input  logic             done_evt,
  input  logic             eng_stop,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] ie,
  output cfg_t             cfg,
  output logic             run_en,
  output logic             irq
);
  logic [NFLAG-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[F_DONE]  = done_evt;
    set_vec[F_ABORT] = abort_evt;
    set_vec[F_COLL]  = coll_evt;
  end

  // one sticky flag per event; a set in the same cycle beats a clear
  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)               flags[f] <= 1'b0;
      else if (set_vec[f])   flags[f] <= 1'b1;
      else if (stat_we && w1c[f]) flags[f] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie  <= '0;
      cfg <= '0;
    end else if (stat_we) begin
      ie  <= ie_in;
      cfg <= cfg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           run_en <= 1'b0;
    else if (eng_stop) run_en <= 1'b0;
    else if (ctl_load) run_en <= ctl_val;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ie);
  end
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              run_en,
  output logic              irq,
  input  logic              seq_active,
  input  logic [IDX_W-1:0]  seq_cmd_ptr,
  input  logic              seq_cmd_done,
  input  logic              seq_at_end,
  input  logic              seq_halt,
  input  logic              seq_wrap,
  input  logic              eng_rx_we,
  input  logic [IDX_W-1:0]  eng_rx_idx,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic [IDX_W-1:0]  eng_rd_idx,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic [CMD_W-1:0]  eng_cmd_data
);
  // ---------------- request decode ----------------
  logic [ADDR_W-1:0] ptr_q;
  region_e           region;
  logic [IDX_W-1:0]  idx;
  sel_e              sel;
  logic wr, rd, ctl_wr, ptr_wr, dat_wr, dat_rd, stat_wr;
  logic coll_hit, coll_reject;
  logic clr_try, abrt_reject, abrt_block, abort_evt;
  logic done_evt, eng_stop, ptr_step;
  logic tx_we, cmd_we;

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] ie;
  cfg_t             cfg;

  assign region = region_e'(ptr_q[ADDR_W-1:IDX_W]);
  assign idx    = ptr_q[IDX_W-1:0];
  assign sel    = sel_e'(bus_sel);

  assign wr      = bus_req &  bus_we;
  assign rd      = bus_req & ~bus_we;
  assign ctl_wr  = wr && sel == SEL_CTL;
  assign ptr_wr  = wr && sel == SEL_PTR;
  assign dat_wr  = wr && sel == SEL_DATA;
  assign dat_rd  = rd && sel == SEL_DATA;
  assign stat_wr = wr && sel == SEL_STAT;

  // write collision: data-port store onto the executing command entry
  assign coll_hit    = dat_wr && region == RG_CMD && seq_active && idx == seq_cmd_ptr;
  assign coll_reject = coll_hit && cfg.coll_err;

  // abort: processor clearing the run enable mid-transfer
  assign clr_try     = ctl_wr && !bus_wdata[0] && run_en && seq_active;
  assign abrt_reject = clr_try &&  cfg.abrt_err;
  assign abrt_block  = clr_try && !cfg.abrt_err && cfg.lock;
  assign abort_evt   = clr_try && !cfg.abrt_err && !cfg.lock;

  // sequencer completion
  assign done_evt = seq_cmd_done && (seq_at_end || seq_halt);
  assign eng_stop = seq_cmd_done && (seq_halt || (seq_at_end && !seq_wrap));

  assign ptr_step = dat_rd || (dat_wr && !coll_reject);
  assign tx_we    = dat_wr && region == RG_TX;
  assign cmd_we   = dat_wr && region == RG_CMD && !coll_reject;

  // ---------------- pointer ----------------
  spiq_ptr #(.AW(ADDR_W)) ptr_i (
    .clk   (clk),
    .rst   (rst),
    .load  (ptr_wr),
    .ldata (bus_wdata[ADDR_W-1:0]),
    .step  (ptr_step),
    .ptr   (ptr_q)
  );

  // ---------------- status / enable ----------------
  spiq_status stat_i (
    .clk       (clk),
    .rst       (rst),
    .stat_we   (stat_wr),
    .w1c       (bus_wdata[NFLAG-1:0]),
    .ie_in     (bus_wdata[IE_LSB+NFLAG-1:IE_LSB]),
    .cfg_in    (cfg_t'(bus_wdata[CFG_LSB+2:CFG_LSB])),
    .ctl_load  (ctl_wr && !abrt_reject && !abrt_block),
    .ctl_val   (bus_wdata[0]),
    .abort_evt (abort_evt),
    .coll_evt  (coll_hit),
    .done_evt  (done_evt),
    .eng_stop  (eng_stop),
    .flags     (flags),
    .ie        (ie),
    .cfg       (cfg),
    .run_en    (run_en),
    .irq       (irq)
  );

  // ---------------- queue memories ----------------
  // transmit and command regions each have one copy per reader
  // (processor at the pointer, engine at eng_rd_idx), written together
  logic [DATA_W-1:0] tx_rd   [2];
  logic [CMD_W-1:0]  cmd_rd  [2];
  logic [DATA_W-1:0] rx_cpu_q;

  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [IDX_W-1:0] rsel;
    assign rsel = (c == 0) ? idx : eng_rd_idx;

    spiq_ram #(.W(DATA_W), .DEPTH(DEPTH)) tx_ram_i (
      .clk   (clk),
      .we    (tx_we),
      .waddr (idx),
      .wdata (bus_wdata[DATA_W-1:0]),
      .raddr (rsel),
      .rdata (tx_rd[c])
    );

    spiq_ram #(.W(CMD_W), .DEPTH(DEPTH)) cmd_ram_i (
      .clk   (clk),
      .we    (cmd_we),
      .waddr (idx),
      .wdata (bus_wdata[CMD_W-1:0]),
      .raddr (rsel),
      .rdata (cmd_rd[c])
    );
  end

  spiq_ram #(.W(DATA_W), .DEPTH(DEPTH)) rx_ram_i (
    .clk   (clk),
    .we    (eng_rx_we),
    .waddr (eng_rx_idx),
    .wdata (eng_rx_data),
    .raddr (idx),
    .rdata (rx_cpu_q)
  );

  assign eng_tx_data  = tx_rd[1];
  assign eng_cmd_data = cmd_rd[1];

  // ---------------- response ----------------
  logic             ack_q, err_q;
  src_e             src_q;
  logic [BUS_W-1:0] reg_q;
  logic [BUS_W-1:0] reg_val;
  src_e             src_d;

  always_comb begin
    unique case (sel)
      SEL_CTL:  reg_val = BUS_W'(run_en);
      SEL_PTR:  reg_val = BUS_W'(ptr_q);
      SEL_STAT: reg_val = pack_status(flags, ie, cfg);
      default:  reg_val = '0;
    endcase
  end

  always_comb begin
    src_d = SRC_ZERO;
    if (rd) begin
      if (sel != SEL_DATA) src_d = SRC_REG;
      else begin
        unique case (region)
          RG_TX:   src_d = SRC_TX;
          RG_RX:   src_d = SRC_RX;
          RG_CMD:  src_d = SRC_CMD;
          default: src_d = SRC_ZERO;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      src_q <= SRC_ZERO;
      reg_q <= '0;
    end else begin
      ack_q <= bus_req;
      err_q <= coll_reject || abrt_reject;
      src_q <= src_d;
      reg_q <= reg_val;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_REG: bus_rdata = reg_q;
      SRC_TX:  bus_rdata = BUS_W'(tx_rd[0]);
      SRC_RX:  bus_rdata = BUS_W'(rx_cpu_q);
      SRC_CMD: bus_rdata = BUS_W'(cmd_rd[0]);
      default: bus_rdata = '0;
    endcase
  end

  assign bus_ack = ack_q;
  assign bus_err = err_q;
endmodule

// File: rtl/spiq_chk.sv
module spiq_chk #(
  parameter int IDX_W = 4,
  localparam int ADDR_W = IDX_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [1:0]        bus_sel,
  input logic              wbit0,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              run_en,
  input logic              seq_active,
  input logic [IDX_W-1:0]  seq_cmd_ptr,
  input logic              seq_cmd_done,
  input logic              seq_at_end,
  input logic              seq_halt,
  input logic              seq_wrap,
  input logic [ADDR_W-1:0] ptr,
  input logic [2:0]        cfg,
  input logic              abort_flag
);
  logic stop_c, clr_c, hit_c;
  assign stop_c = seq_cmd_done && (seq_halt || (seq_at_end && !seq_wrap));
  assign clr_c  = bus_req && bus_we && bus_sel == 2'd0 && !wbit0 && seq_active && run_en;
  assign hit_c  = bus_req && bus_we && bus_sel == 2'd2 && seq_active &&
                  ptr[ADDR_W-1:IDX_W] == 2'd2 && ptr[IDX_W-1:0] == seq_cmd_ptr;

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);
  assert_err_with_ack_R2: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack);
  assert_coll_reject_R7: assert property (@(posedge clk) disable iff (rst)
    hit_c && cfg[1] |=> bus_err && ptr == $past(ptr));
  assert_abort_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_c && !cfg[0] && !cfg[2] |=> !run_en && abort_flag);
  assert_abort_reject_R9: assert property (@(posedge clk) disable iff (rst)
    clr_c && cfg[0] && !stop_c |=> bus_err && run_en && abort_flag == $past(abort_flag));
  assert_lockout_R10: assert property (@(posedge clk) disable iff (rst)
    clr_c && !cfg[0] && cfg[2] && !stop_c |=> !bus_err && run_en);
  assert_engine_stop_R11: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !run_en);
endmodule

bind spiq_ctrl spiq_chk #(.IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_sel      (bus_sel),
  .wbit0        (bus_wdata[0]),
  .bus_ack      (bus_ack),
  .bus_err      (bus_err),
  .run_en       (run_en),
  .seq_active   (seq_active),
  .seq_cmd_ptr  (seq_cmd_ptr),
  .seq_cmd_done (seq_cmd_done),
  .seq_at_end   (seq_at_end),
  .seq_halt     (seq_halt),
  .seq_wrap     (seq_wrap),
  .ptr          (ptr_q),
  .cfg          (cfg),
  .abort_flag   (flags[1])
);

// File: tb/spiq_ctrl_tb.sv
module spiq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        bus_req = 0, bus_we = 0;
  logic [1:0]  bus_sel = 0;
  logic [15:0] bus_wdata = 0;
  logic        bus_ack, bus_err, run_en, irq;
  logic [15:0] bus_rdata;
  logic        seq_active = 0, seq_cmd_done = 0, seq_at_end = 0, seq_halt = 0, seq_wrap = 0;
  logic [3:0]  seq_cmd_ptr = 0;
  logic        eng_rx_we = 0;
  logic [3:0]  eng_rx_idx = 0, eng_rd_idx = 0;
  logic [15:0] eng_rx_data = 0;
  logic [15:0] eng_tx_data;
  logic [7:0]  eng_cmd_data;

  spiq_ctrl dut_i (.*);

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_tx [16];
  logic [7:0]  m_cmd [16];
  logic [15:0] m_rx [16];
  logic [5:0]  m_ptr;
  logic        ack, err;
  logic [15:0] rdv;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] sel, input logic we, input logic [15:0] wd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_sel = sel; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    ack = bus_ack; err = bus_err; rdv = bus_rdata;
  endtask

  task automatic seq_pulse(input logic at_end, input logic halt);
    @(negedge clk);
    seq_cmd_done = 1; seq_at_end = at_end; seq_halt = halt;
    @(negedge clk);
    seq_cmd_done = 0; seq_at_end = 0; seq_halt = 0;
  endtask

  function automatic logic [15:0] model_read(input logic [5:0] p);
    case (p[5:4])
      2'd0:    return m_tx[p[3:0]];
      2'd1:    return m_rx[p[3:0]];
      2'd2:    return {8'h00, m_cmd[p[3:0]]};
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 run_en", run_en, 0);
    op(2'd0, 0, 0); check("R1 ctl", rdv, 0);
    op(2'd1, 0, 0); check("R1 ptr", rdv, 0);
    check("R2 ack", ack, 1); check("R2 no err", err, 0);
    op(2'd3, 0, 0); check("R1 stat", rdv, 0);

    // R5 engine fills receive region
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      eng_rx_we = 1; eng_rx_idx = 4'(i); eng_rx_data = 16'(32'hA000 + i * 7);
      m_rx[i] = 16'(32'hA000 + i * 7);
    end
    @(negedge clk) eng_rx_we = 0;

    // R4 fill transmit and command regions through the data port
    op(2'd1, 1, 16'd0);
    for (int i = 0; i < 16; i++) begin
      m_tx[i] = 16'($urandom);
      op(2'd2, 1, m_tx[i]);
    end
    op(2'd1, 0, 0); check("R3 ptr after 16 writes", rdv, 16);
    op(2'd1, 1, 16'd32);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      m_cmd[i] = v[7:0];
      op(2'd2, 1, v);
    end
    op(2'd1, 1, 16'd0);
    op(2'd2, 0, 0); check("R4 tx readback", rdv, m_tx[0]);
    op(2'd1, 1, 16'd37);
    op(2'd2, 0, 0); check("R4 cmd readback low byte", rdv, {8'h00, m_cmd[5]});
    @(negedge clk) eng_rd_idx = 4'd9;
    @(negedge clk);
    check("R4 engine tx port", eng_tx_data, m_tx[9]);
    check("R4 engine cmd port", eng_cmd_data, m_cmd[9]);

    // R5 processor write to receive region discarded, pointer advances
    op(2'd1, 1, 16'd21);
    op(2'd2, 1, 16'h1234);
    op(2'd1, 0, 0); check("R5 ptr advances", rdv, 22);
    op(2'd1, 1, 16'd21);
    op(2'd2, 0, 0); check("R5 rx unchanged", rdv, m_rx[5]);

    // R3 unmapped region and wrap
    op(2'd1, 1, 16'd50);
    op(2'd2, 0, 0); check("R3 unmapped reads 0", rdv, 0);
    op(2'd1, 1, 16'd63);
    op(2'd2, 1, 16'h7777);
    op(2'd1, 0, 0); check("R3 wrap to 0", rdv, 0);

    // R12 status fields
    op(2'd3, 1, 16'hFFF8);
    op(2'd3, 0, 0); check("R12 enables readback, reserved zero", rdv, 16'h0770);
    op(2'd3, 1, 16'h0000);

    // R6 collision without error enable
    @(negedge clk) begin seq_active = 1; seq_cmd_ptr = 4'd3; end
    op(2'd1, 1, 16'd35);
    op(2'd2, 1, 16'h00AB); check("R6 no err", err, 0);
    m_cmd[3] = 8'hAB;
    op(2'd1, 0, 0); check("R6 ptr advanced", rdv, 36);
    op(2'd3, 0, 0); check("R6 collision flag", rdv, 16'h0004);
    op(2'd3, 1, 16'h0000);
    op(2'd3, 0, 0); check("R12 write 0 keeps flag", rdv, 16'h0004);
    op(2'd3, 1, 16'h0004);
    op(2'd3, 0, 0); check("R12 write 1 clears flag", rdv, 16'h0000);

    // R7 collision with error enable
    op(2'd3, 1, 16'h0200);
    op(2'd1, 1, 16'd35);
    op(2'd2, 1, 16'h005C); check("R7 err", err, 1);
    op(2'd1, 0, 0); check("R7 ptr held", rdv, 35);
    op(2'd2, 0, 0); check("R7 entry unchanged", rdv, 16'h00AB);
    op(2'd3, 0, 0); check("R7 flag set", rdv, 16'h0204);
    op(2'd1, 1, 16'd36);
    op(2'd2, 1, 16'h00C1); check("R7 other entry accepted", err, 0);
    m_cmd[4] = 8'hC1;
    op(2'd3, 1, 16'h0007);

    // R8 abort
    op(2'd0, 1, 16'h0001); check("R8 run set", run_en, 1);
    op(2'd0, 1, 16'h0000);
    check("R8 run cleared", run_en, 0);
    op(2'd3, 0, 0); check("R8 abort flag", rdv, 16'h0002);
    // R9 abort error
    op(2'd3, 1, 16'h0102);
    op(2'd0, 1, 16'h0001);
    op(2'd0, 1, 16'h0000); check("R9 err", err, 1);
    check("R9 run kept", run_en, 1);
    op(2'd3, 0, 0); check("R9 no abort flag", rdv, 16'h0100);
    op(2'd3, 1, 16'h0500);
    op(2'd0, 1, 16'h0000); check("R9 precedence over lock", err, 1);
    // R10 lock-out
    op(2'd3, 1, 16'h0400);
    op(2'd0, 1, 16'h0000); check("R10 no err", err, 0);
    check("R10 run kept", run_en, 1);
    op(2'd3, 0, 0); check("R10 no flag", rdv, 16'h0400);
    @(negedge clk) seq_active = 0;
    op(2'd0, 1, 16'h0000); check("R10 idle clear", run_en, 0);
    op(2'd3, 1, 16'h0000);

    // R11 finished flag and engine stop
    op(2'd0, 1, 16'h0001);
    seq_pulse(1, 0);
    check("R11 end stops run", run_en, 0);
    op(2'd3, 0, 0); check("R11 finished flag", rdv, 16'h0001);
    op(2'd3, 1, 16'h0001);
    @(negedge clk) seq_wrap = 1;
    op(2'd0, 1, 16'h0001);
    seq_pulse(1, 0);
    check("R11 wrap keeps run", run_en, 1);
    op(2'd3, 0, 0); check("R11 wrap sets flag", rdv, 16'h0001);
    seq_pulse(0, 1);
    check("R11 halt stops run", run_en, 0);
    @(negedge clk) seq_wrap = 0;
    seq_pulse(0, 0);
    op(2'd3, 1, 16'h0001);
    op(2'd3, 0, 0); check("R11 plain completion no flag", rdv, 0);

    // R13 interrupt timing
    check("R13 disabled flag no irq", irq, 0);
    op(2'd3, 1, 16'h0011);
    @(negedge clk) begin seq_cmd_done = 1; seq_at_end = 1; end
    @(negedge clk) begin seq_cmd_done = 0; seq_at_end = 0; end
    check("R13 irq one cycle late", irq, 0);
    @(negedge clk);
    check("R13 irq raised", irq, 1);
    op(2'd3, 1, 16'h0011);
    check("R13 irq still high at clear", irq, 1);
    @(negedge clk);
    check("R13 irq dropped", irq, 0);
    op(2'd3, 1, 16'h0000);

    // random data-port traffic (R3, R4, R5)
    op(2'd1, 1, 16'd0); m_ptr = 0;
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) begin
        m_ptr = 6'($urandom);
        op(2'd1, 1, {10'd0, m_ptr});
      end else if (r < 5) begin
        logic [15:0] v;
        v = 16'($urandom);
        op(2'd2, 1, v);
        if (m_ptr[5:4] == 2'd0) m_tx[m_ptr[3:0]] = v;
        if (m_ptr[5:4] == 2'd2) m_cmd[m_ptr[3:0]] = v[7:0];
        m_ptr = m_ptr + 6'd1;
      end else begin
        op(2'd2, 0, 0);
        check("R3 R4 R5 random read", rdv, model_read(m_ptr));
        m_ptr = m_ptr + 6'd1;
      end
    end
    op(2'd1, 0, 0); check("R3 random final ptr", rdv, {10'd0, m_ptr});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule